// File: doc/BRIEF.md
# Five-Operation Combinational ALU

This block is a purely combinational arithmetic-logic unit for a narrow datapath. It takes two unsigned operands, a carry input and a three-bit operation select, and returns a result word plus a carry output. Five operations are decoded: add with carry, bitwise AND, bitwise XOR, and a one-bit shift in each direction. Both shifts pass a bit through the carry. The three spare select codes return zero on every output bit.

The operand width is a parameter with a default of 16 bits. The carry and shift behaviour scales with it. A second parameter chooses how the adder is built: as an inferred adder, or as an explicit ripple chain of full-adder cells. The block holds no state, so a result is valid once the inputs have settled. There is no overflow flag, and no flag other than the carry.

Top module: `alu5_core`

## Requirements
- R1: Select code 3'b000 adds: {carry_out, result} equals opnd_a + opnd_b + carry_in, taken as a (WIDTH+1)-bit unsigned sum.
- R2: Select code 3'b001 returns opnd_a AND opnd_b bit by bit, with carry_out at 0.
- R3: Select code 3'b010 returns opnd_a XOR opnd_b bit by bit, with carry_out at 0.
- R4: Select code 3'b011 shifts left by one: result is {opnd_a[WIDTH-2:0], carry_in} and carry_out is opnd_a[WIDTH-1].
- R5: Select code 3'b100 shifts right by one: result is {1'b0, opnd_a[WIDTH-1:1]} and carry_out is opnd_a[0].
- R6: Select codes 3'b101, 3'b110 and 3'b111 drive result and carry_out to all zeros, whatever the operands and carry_in are.
- R7: opnd_b has no effect on either output under the two shift codes (3'b011, 3'b100).
- R8: carry_in has no effect on either output under codes 3'b001, 3'b010 and 3'b100.
- R9: The outputs depend only on the present inputs. The same inputs give the same outputs whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation select code |
| opnd_a | input | WIDTH | First operand; also the value shifted by the shift codes |
| opnd_b | input | WIDTH | Second operand for add, AND and XOR |
| carry_in | input | 1 | Carry into the adder and into bit 0 of the left shift |
| result | output | WIDTH | Result word |
| carry_out | output | 1 | Carry out, or the bit shifted out |

## Verification
The bench targets the carry at both ends of the word. A full-ones add with carry set must give all ones and a carry of 1; an adder that dropped carry_in or truncated the sum would give a wrong word or lose the carry. The shift vectors set both end bits of the word together, so a shift that lost the outgoing bit, filled the vacant bit wrongly or went the wrong way shows up at once. The bench also applies the three spare codes with all-ones operands, and it varies opnd_b and carry_in where they must be ignored. A decoder that reused another operation for a spare code, or that let an unused input leak through, changes the outputs in those checks.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int OP_BITS = 3;

   localparam logic [OP_BITS-1:0] OP_ADD = 3'b000;
   localparam logic [OP_BITS-1:0] OP_AND = 3'b001;
   localparam logic [OP_BITS-1:0] OP_XOR = 3'b010;
   localparam logic [OP_BITS-1:0] OP_SHL = 3'b011;
   localparam logic [OP_BITS-1:0] OP_SHR = 3'b100;

   localparam int ADDER_INFERRED = 0;
   localparam int ADDER_RIPPLE   = 1;

   function automatic logic op_is_defined(input logic [OP_BITS-1:0] code);
      return (code == OP_ADD) || (code == OP_AND) || (code == OP_XOR) ||
             (code == OP_SHL) || (code == OP_SHR);
   endfunction

endpackage

// File: rtl/alu_add_unit.sv
module alu_add_unit #(
   parameter int WIDTH       = 16,
   parameter int ADDER_STYLE = 1
) (
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   input  logic             c_in,
   output logic [WIDTH-1:0] sum,
   output logic             c_out
);

   localparam int EXT_W = WIDTH + 1;

   generate
      if (ADDER_STYLE == alu_pkg::ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = c_in;
         for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            assign sum[i]     = in_a[i] ^ in_b[i] ^ chain[i];
            assign chain[i+1] = (in_a[i] & in_b[i]) | (chain[i] & (in_a[i] ^ in_b[i]));
         end
         assign c_out = chain[WIDTH];
      end else begin : g_inferred
         logic [EXT_W-1:0] wide;
         assign wide  = {1'b0, in_a} + {1'b0, in_b} + {{WIDTH{1'b0}}, c_in};
         assign sum   = wide[WIDTH-1:0];
         assign c_out = wide[WIDTH];
      end
   endgenerate

   // R1: taking the first operand back out of the extended sum leaves the second plus carry
   always_comb begin
      p_add_sum_r1: assert (({c_out, sum} - {1'b0, in_a}) ==
                            ({1'b0, in_b} + {{WIDTH{1'b0}}, c_in}))
         else $error("adder sum inconsistent with operands");
   end

endmodule

// File: rtl/alu_bitwise_unit.sv
module alu_bitwise_unit #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   output logic [WIDTH-1:0] and_y,
   output logic [WIDTH-1:0] xor_y
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign and_y[i] = in_a[i] & in_b[i];
      assign xor_y[i] = in_a[i] ^ in_b[i];
   end

   // R2/R3: a set AND bit means both inputs set, so the XOR bit there must be clear
   always_comb begin
      p_and_xor_disjoint_r3: assert ((and_y & xor_y) == '0)
         else $error("AND and XOR outputs overlap");
   end

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] in_a,
   input  logic             c_in,
   output logic [WIDTH-1:0] shl_y,
   output logic             shl_c,
   output logic [WIDTH-1:0] shr_y,
   output logic             shr_c
);

   assign {shl_c, shl_y} = {in_a, c_in};
   assign {shr_y, shr_c} = {1'b0, in_a};

   always_comb begin
      // R4: left result rejoined with its carry reproduces the operand and the carry input
      p_shl_carry_r4: assert ({shl_c, shl_y[WIDTH-1:1]} == in_a && shl_y[0] == c_in)
         else $error("left shift lost a bit");
      // R5: right result has a clear top bit and, with its carry, reproduces the operand
      p_shr_carry_r5: assert (shr_y[WIDTH-1] == 1'b0 && {shr_y[WIDTH-2:0], shr_c} == in_a)
         else $error("right shift lost a bit");
   end

endmodule

// File: rtl/alu5_core.sv
module alu5_core #(
   parameter int WIDTH       = 16,
   parameter int ADDER_STYLE = 1
) (
   input  logic [2:0]       op_sel,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);

   import alu_pkg::*;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu5_core: WIDTH must be at least 2");
      end
      if (ADDER_STYLE != ADDER_INFERRED && ADDER_STYLE != ADDER_RIPPLE) begin : g_bad_style
         $error("alu5_core: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   logic [WIDTH-1:0] add_y, and_y, xor_y, shl_y, shr_y;
   logic             add_c, shl_c, shr_c;

   alu_add_unit #(.WIDTH(WIDTH), .ADDER_STYLE(ADDER_STYLE)) u_add (
      .in_a (opnd_a),
      .in_b (opnd_b),
      .c_in (carry_in),
      .sum  (add_y),
      .c_out(add_c)
   );

   alu_bitwise_unit #(.WIDTH(WIDTH)) u_bitwise (
      .in_a (opnd_a),
      .in_b (opnd_b),
      .and_y(and_y),
      .xor_y(xor_y)
   );

   alu_shift_unit #(.WIDTH(WIDTH)) u_shift (
      .in_a (opnd_a),
      .c_in (carry_in),
      .shl_y(shl_y),
      .shl_c(shl_c),
      .shr_y(shr_y),
      .shr_c(shr_c)
   );

   always_comb begin
      case (op_sel)
         OP_ADD:  {carry_out, result} = {add_c, add_y};
         OP_AND:  {carry_out, result} = {1'b0, and_y};
         OP_XOR:  {carry_out, result} = {1'b0, xor_y};
         OP_SHL:  {carry_out, result} = {shl_c, shl_y};
         OP_SHR:  {carry_out, result} = {shr_c, shr_y};
         default: {carry_out, result} = '0;
      endcase
   end

   always_comb begin
      // R6: spare codes give an all-zero output
      p_spare_zero_r6: assert (op_is_defined(op_sel) || {carry_out, result} == '0)
         else $error("spare code produced nonzero output");
      // R2/R3: the logic codes never raise the carry
      p_logic_no_carry_r2: assert (!(op_sel == OP_AND || op_sel == OP_XOR) || carry_out == 1'b0)
         else $error("logic code raised carry");
      // R2: an AND result never sets a bit that the first operand has clear
      p_and_subset_r2: assert (op_sel != OP_AND || (result & ~opnd_a) == '0)
         else $error("AND result outside operand a");
   end

endmodule

// File: tb/alu5_core_tb.sv
`timescale 1ns/1ps
module alu5_core_tb;

   localparam int W = 16;
   localparam int NVEC = 15;
   localparam int ENT_W = 3 + W + W + 1 + 1 + W;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic [2:0]   op_sel = '0;
   logic [W-1:0] opnd_a = '0;
   logic [W-1:0] opnd_b = '0;
   logic         carry_in = 1'b0;
   logic [W-1:0] result;
   logic         carry_out;

   int checks = 0;
   int fails  = 0;

   alu5_core #(.WIDTH(W), .ADDER_STYLE(1)) u_dut (
      .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
      .result(result), .carry_out(carry_out)
   );

   // {op, a, b, cin, expected cout, expected result}
   localparam logic [ENT_W-1:0] VEC [NVEC] = '{
      {3'b000, 16'h0001, 16'h0001, 1'b0, 1'b0, 16'h0002},
      {3'b000, 16'hFFFF, 16'h0001, 1'b0, 1'b1, 16'h0000},
      {3'b000, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF},
      {3'b000, 16'h1234, 16'h4321, 1'b1, 1'b0, 16'h5556},
      {3'b001, 16'hF0F0, 16'h3C3C, 1'b1, 1'b0, 16'h3030},
      {3'b001, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 16'hFFFF},
      {3'b010, 16'hF0F0, 16'h3C3C, 1'b1, 1'b0, 16'hCCCC},
      {3'b010, 16'hAAAA, 16'hAAAA, 1'b1, 1'b0, 16'h0000},
      {3'b011, 16'h8001, 16'hFFFF, 1'b1, 1'b1, 16'h0003},
      {3'b011, 16'h4000, 16'h0000, 1'b0, 1'b0, 16'h8000},
      {3'b100, 16'h8001, 16'hFFFF, 1'b1, 1'b1, 16'h4000},
      {3'b100, 16'hFFFE, 16'h0000, 1'b1, 1'b0, 16'h7FFF},
      {3'b101, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 16'h0000},
      {3'b110, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 16'h0000},
      {3'b111, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 16'h0000}
   };

   function automatic string req_of(input logic [2:0] op);
      case (op)
         3'b000:  return "R1";
         3'b001:  return "R2";
         3'b010:  return "R3";
         3'b011:  return "R4";
         3'b100:  return "R5";
         default: return "R6";
      endcase
   endfunction

   function automatic logic [W:0] model(input logic [2:0] op, input logic [W-1:0] a,
                                        input logic [W-1:0] b, input logic c);
      case (op)
         3'b000:  return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
         3'b001:  return {1'b0, a & b};
         3'b010:  return {1'b0, a ^ b};
         3'b011:  return {a, c};
         3'b100:  return {a[0], 1'b0, a[W-1:1]};
         default: return '0;
      endcase
   endfunction

   task automatic apply(input logic [2:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic c);
      @(negedge clk);
      op_sel = op; opnd_a = a; opnd_b = b; carry_in = c;
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [W:0] exp);
      checks++;
      if ({carry_out, result} !== exp) begin
         fails++;
         $display("FAIL %s: op=%b a=%h b=%h cin=%b got cout=%b res=%h exp cout=%b res=%h",
                  req, op_sel, opnd_a, opnd_b, carry_in, carry_out, result, exp[W], exp[W-1:0]);
      end
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [W:0] ref_a;
      repeat (2) @(posedge clk);
      #1;
      // reset-time state: all inputs zero -> add of zeros gives zero (R1)
      check("R1", '0);
      rst = 1'b0;

      // vector table covering R1..R6
      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][ENT_W-1 -: 3], VEC[i][ENT_W-4 -: W], VEC[i][ENT_W-4-W -: W],
               VEC[i][W+1]);
         check(req_of(VEC[i][ENT_W-1 -: 3]), VEC[i][W:0]);
      end

      // R7: opnd_b ignored by shifts
      apply(3'b011, 16'hA5C3, 16'h0000, 1'b0);
      ref_a = {carry_out, result};
      apply(3'b011, 16'hA5C3, 16'hFFFF, 1'b0);
      check("R7", ref_a);
      apply(3'b100, 16'h5A3C, 16'h0000, 1'b1);
      ref_a = {carry_out, result};
      apply(3'b100, 16'h5A3C, 16'h9999, 1'b1);
      check("R7", ref_a);

      // R8: carry_in ignored by AND, XOR and right shift
      for (int k = 1; k <= 4; k++) begin
         if (k == 3) continue;
         apply(3'(k), 16'h6C93, 16'h3F0F, 1'b0);
         ref_a = {carry_out, result};
         apply(3'(k), 16'h6C93, 16'h3F0F, 1'b1);
         check("R8", ref_a);
      end

      // R9: same inputs after different history give the same output
      apply(3'b000, 16'hFFFF, 16'hFFFF, 1'b1);
      apply(3'b000, 16'h0101, 16'h0202, 1'b0);
      check("R9", 17'h00303);
      apply(3'b011, 16'hFFFF, 16'h0000, 1'b1);
      apply(3'b000, 16'h0101, 16'h0202, 1'b0);
      check("R9", 17'h00303);

      // random sweep over every code
      for (int op = 0; op < 8; op++) begin
         for (int n = 0; n < 200; n++) begin
            logic [W-1:0] ra, rb;
            logic         rc;
            ra = W'($urandom);
            rb = W'($urandom);
            rc = 1'($urandom);
            apply(3'(op), ra, rb, rc);
            check(req_of(3'(op)), model(3'(op), ra, rb, rc));
         end
      end

      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule